// File: doc/BRIEF.md
# MAC Interrupt Event and Mask Unit

This block gathers single-cycle event pulses raised by the status logic of a network MAC. It holds them in a 32-bit sticky event register. Software reads that register and acknowledges events by writing ones to the bits it has handled. A 32-bit mask register, read and written through the same port, chooses which events may interrupt.

Only four events can interrupt, and their enable bits sit exactly 16 positions above the event bits they gate. Three ECC error events (timestamp FIFO at 13, transmit frame at 9, receive frame at 8) are combined onto an error interrupt line. The magic-packet event at 14 drives a separate notification line. All other implemented events are latched and can be read, but they never raise an interrupt. Both lines are registered level outputs.

The register port has two word addresses. Address 0 is the event register, where a write clears every bit written as one. Address 1 is the mask register, which is plain read/write. Any other address reads zero, and writes to it are ignored.

Top module: `mac_irq_unit`

## Requirements
- R1: After a synchronous active-low reset, the event register reads 0, the mask register reads 0x6300_0000 (enables at bits 30, 29, 25 and 24), and both interrupt outputs are low.
- R2: A one on an implemented bit of `evt_pulse` sets that event bit at the next clock edge. The bit stays set after the pulse ends, until software clears it. The implemented event bits are 31, 30, 29, 14 through 4, and 2 through 0.
- R3: Event bits 28 through 15 and bit 3 are not implemented. They always read 0, even when pulsed.
- R4: A write to address 0 clears each event bit whose write-data bit is one and leaves every other bit unchanged. Writing 0xFFFF_FFFF clears all events, and writing 0 changes nothing.
- R5: When an event pulse and a clearing write for the same bit fall in the same cycle, the bit ends up set. Other bits in the same write are still cleared.
- R6: The mask register at address 1 stores and returns all 32 bits of the value written. Address 2 and address 3 read 0, and writes to them change no state.
- R7: `irq_err` is high in the cycle after the event register holds at least one of bits 13, 9 or 8 whose mask bit (event bit + 16: 29, 25, 24) is also set. It is a registered output, so it rises one clock after the event bit.
- R8: `irq_norm` follows event bit 14 gated by mask bit 30, with the same one-cycle registered timing as `irq_err`.
- R9: No event bit other than 13, 9, 8 and 14 affects either interrupt output, whatever the mask holds.
- R10: An interrupt output stays high for as long as an enabled event in its group stays set. It falls one cycle after the last such event is cleared or its mask bit is written to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_pulse | input | 32 | Event pulses, one bit per event position |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address: 0 event, 1 mask |
| reg_wdata | input | 32 | Write data (ones clear bits at address 0) |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_err | output | 1 | Level interrupt for ECC error events |
| irq_norm | output | 1 | Level interrupt for magic-packet notification |

## Verification
The bench pulses every one of the 32 event positions in turn, under three masks: the reset default, all zeros and all ones. For each position it predicts the read value and both interrupt lines from the stated bit sets. This separates implemented bits from reserved ones, error events from the notification event, and gated sources from ungated ones. It also separates a correct 16-bit mask offset from a wrong one. Separate patterns cover the following:
- a zero write against a full write to the event register;
- a clear that collides with a pulse on the same bit, next to a bit that must still clear;
- checkerboard mask values and the unused addresses;
- interrupts held over several cycles and then dropped, either by acknowledging the event or by removing its enable.

// File: rtl/mac_irq_pkg.sv
// Package: shared constants of the MAC interrupt event/mask unit.
// Assumes a 32-bit register width; the bit sets below are fixed by the
// event layout that the status logic of the MAC drives.
package mac_irq_pkg;
    localparam int unsigned REG_W       = 32;
    localparam int unsigned MASK_SHIFT  = 16;
    // Implemented event positions: 31..29, 14..4, 2..0
    localparam logic [REG_W-1:0] EVT_IMPL  = 32'hE000_7FF7;
    // Error group: timestamp ECC (13), Tx ECC (9), Rx ECC (8)
    localparam logic [REG_W-1:0] ERR_GROUP = 32'h0000_2300;
    // Notification group: magic packet (14)
    localparam logic [REG_W-1:0] NRM_GROUP = 32'h0000_4000;
    // Mask value after reset: every maskable source enabled
    localparam logic [REG_W-1:0] MASK_RST  = (ERR_GROUP | NRM_GROUP) << MASK_SHIFT;
    // Word addresses of the register port
    localparam int unsigned ADDR_W    = 2;
    localparam logic [ADDR_W-1:0] ADDR_EVT  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_MASK = 2'd1;
endpackage

// File: rtl/mac_irq_evt_reg.sv
// Module: sticky event register with write-one-to-clear.
// Each implemented bit sets on a pulse and clears on a one in clr_vec;
// a pulse wins over a clear in the same cycle. Bits outside IMPL are
// not built and read as zero. Assumes pulses are synchronous to clk.
module mac_irq_evt_reg #(
    parameter int unsigned             W    = 32,
    parameter logic [W-1:0]            IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pulse,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] evt_q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (IMPL[i]) begin : g_impl
            // Purpose: hold one event bit, set dominating clear.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    evt_q[i] <= 1'b0;
                else if (pulse[i])
                    evt_q[i] <= 1'b1;
                else if (clr_vec[i])
                    evt_q[i] <= 1'b0;
            end
        end else begin : g_rsvd
            assign evt_q[i] = 1'b0;
        end
    end
endmodule

// File: rtl/mac_irq_mask_reg.sv
// Module: plain read/write mask register with a parameter reset value.
// Assumes the write strobe is already qualified by the address decode.
module mac_irq_mask_reg #(
    parameter int unsigned  W       = 32,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask_q
);
    // Purpose: store the mask word written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= RST_VAL;
        else if (we)
            mask_q <= wdata;
    end
endmodule

// File: rtl/mac_irq_line.sv
// Module: one registered interrupt line.
// Aligns the mask down by SHIFT so each enable meets its event bit,
// keeps only the GROUP bits, and registers the OR as a level output.
module mac_irq_line #(
    parameter int unsigned  W     = 32,
    parameter int unsigned  SHIFT = 16,
    parameter logic [W-1:0] GROUP = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] mask,
    output logic         irq
);
    logic [W-1:0] aligned;
    logic         any_hit;

    // Purpose: move each enable bit onto the event bit it gates.
    always_comb begin
        aligned = mask >> SHIFT;
        any_hit = |(evt & aligned & GROUP);
    end

    // Purpose: register the line so the output is glitch-free.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else
            irq <= any_hit;
    end
endmodule

// File: rtl/mac_irq_unit.sv
// Module: top of the MAC interrupt event/mask unit.
// Decodes the two-word register port, holds the event and mask words,
// and drives the error and notification interrupt lines.
// Assumes one register access per cycle; reads are combinational.
module mac_irq_unit
    import mac_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  evt_pulse,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq_err,
    output logic              irq_norm
);
    logic [REG_W-1:0] evt_q;
    logic [REG_W-1:0] mask_q;
    logic [REG_W-1:0] clr_vec;
    logic             mask_we;

    // Purpose: decode writes into a clear vector and a mask strobe.
    always_comb begin
        clr_vec = (reg_wr && reg_addr == ADDR_EVT) ? reg_wdata : '0;
        mask_we = reg_wr && reg_addr == ADDR_MASK;
    end

    // Purpose: return the addressed word, zero for unused addresses.
    always_comb begin
        case (reg_addr)
            ADDR_EVT:  reg_rdata = evt_q;
            ADDR_MASK: reg_rdata = mask_q;
            default:   reg_rdata = '0;
        endcase
    end

    mac_irq_evt_reg #(.W(REG_W), .IMPL(EVT_IMPL)) u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .pulse   (evt_pulse),
        .clr_vec (clr_vec),
        .evt_q   (evt_q)
    );

    mac_irq_mask_reg #(.W(REG_W), .RST_VAL(MASK_RST)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (mask_we),
        .wdata  (reg_wdata),
        .mask_q (mask_q)
    );

    mac_irq_line #(.W(REG_W), .SHIFT(MASK_SHIFT), .GROUP(ERR_GROUP)) u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt_q),
        .mask  (mask_q),
        .irq   (irq_err)
    );

    mac_irq_line #(.W(REG_W), .SHIFT(MASK_SHIFT), .GROUP(NRM_GROUP)) u_nrm (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt_q),
        .mask  (mask_q),
        .irq   (irq_norm)
    );
endmodule

// File: rtl/mac_irq_unit_chk.sv
// Module: assertion checker for mac_irq_unit, attached by bind below.
// Observes ports plus the event and mask words held inside the top.
module mac_irq_unit_chk
    import mac_irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [REG_W-1:0]  evt_pulse,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [REG_W-1:0]  reg_wdata,
    input logic [REG_W-1:0]  evt_q,
    input logic [REG_W-1:0]  mask_q,
    input logic              irq_err,
    input logic              irq_norm
);
    logic [REG_W-1:0] wr_clr;
    logic [REG_W-1:0] seen;

    // Purpose: independent view of what the port asks to clear.
    always_comb begin
        wr_clr = (reg_wr && reg_addr == 2'd0) ? reg_wdata : '0;
        seen   = evt_pulse & EVT_IMPL;
    end

    // R2 and R5: a pulsed implemented bit is set one cycle later, clear or not
    p_pulse_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((evt_q & $past(seen)) == $past(seen)));

    // R3: reserved positions never hold a one
    p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_q & ~EVT_IMPL) == '0);

    // R4: bits neither pulsed nor cleared keep their value
    p_untouched_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (((evt_q ^ $past(evt_q)) & ~($past(wr_clr) | $past(evt_pulse))) == '0));

    // R6: the mask only moves on a write to its address
    p_mask_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !($past(reg_wr) && $past(reg_addr) == 2'd1) |-> $stable(mask_q));

    // R7: error line reflects last cycle's gated error events
    p_err_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq_err == (($past(evt_q[13]) && $past(mask_q[29])) ||
                                      ($past(evt_q[9])  && $past(mask_q[25])) ||
                                      ($past(evt_q[8])  && $past(mask_q[24])))));

    // R8: notification line reflects last cycle's gated magic-packet event
    p_nrm_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq_norm == ($past(evt_q[14]) && $past(mask_q[30]))));

    // R9: with no group event pending, both lines are low next cycle
    p_no_group_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_q & 32'h0000_6300) == '0 |=> (!irq_err && !irq_norm));
endmodule

bind mac_irq_unit mac_irq_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_pulse (evt_pulse),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .evt_q     (evt_q),
    .mask_q    (mask_q),
    .irq_err   (irq_err),
    .irq_norm  (irq_norm)
);

// File: tb/tb_mac_irq_unit.sv
`timescale 1ns/1ps
// Bench: sweeps every event position under several masks and predicts
// register contents and interrupt lines arithmetically from the bit sets.
module tb_mac_irq_unit;
    localparam logic [31:0] IMPL  = 32'hE000_7FF7;
    localparam logic [31:0] ERRS  = 32'h0000_2300;
    localparam logic [31:0] NRMS  = 32'h0000_4000;
    localparam logic [31:0] MDEF  = 32'h6300_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] evt_pulse = '0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_err;
    logic        irq_norm;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mac_irq_unit dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_pulse (evt_pulse),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_err   (irq_err),
        .irq_norm  (irq_norm)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic pulse(input logic [31:0] p);
        evt_pulse = p;
        @(negedge clk);
        evt_pulse = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    initial begin
        logic [31:0] v;
        logic [31:0] masks [3];
        masks[0] = MDEF; masks[1] = 32'h0; masks[2] = 32'hFFFF_FFFF;
        idle(3);
        // R1: reset state
        rd(2'd0, v); check("R1 event", v, 32'h0);
        rd(2'd1, v); check("R1 mask", v, MDEF);
        check("R1 irq", {30'd0, irq_err, irq_norm}, 32'h0);
        rst_n = 1'b1;
        idle(1);

        // R2 R3 R4 R7 R8 R9: sweep each position under three masks
        for (int m = 0; m < 3; m++) begin
            wr(2'd1, masks[m]);
            for (int b = 0; b < 32; b++) begin
                logic [31:0] bitv;
                bitv = 32'h1 << b;
                pulse(bitv);
                check("R7 registered delay", {31'd0, irq_err | irq_norm}, 32'h0);
                idle(1);
                rd(2'd0, v); check("R2/R3 latch", v, bitv & IMPL);
                check("R7/R9 err", {31'd0, irq_err},
                      {31'd0, |(bitv & ERRS & (masks[m] >> 16))});
                check("R8/R9 nrm", {31'd0, irq_norm},
                      {31'd0, |(bitv & NRMS & (masks[m] >> 16))});
                wr(2'd0, bitv);
                idle(1);
                rd(2'd0, v); check("R4 clear", v, 32'h0);
                check("R10 drop", {30'd0, irq_err, irq_norm}, 32'h0);
            end
        end
        wr(2'd1, MDEF);

        // R4: zero write keeps, full write clears
        pulse(32'hFFFF_FFFF);
        wr(2'd0, 32'h0);
        rd(2'd0, v); check("R4 zero write", v, IMPL);
        wr(2'd0, 32'h0000_00F0);
        rd(2'd0, v); check("R4 partial clear", v, IMPL & ~32'h0000_00F0);
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, v); check("R4 clear all", v, 32'h0);

        // R5: pulse and clear collide on bit 9, bit 8 still clears
        pulse(32'h0000_0100);
        evt_pulse = 32'h0000_0200;
        wr(2'd0, 32'h0000_0300);
        evt_pulse = '0;
        rd(2'd0, v); check("R5 collision", v, 32'h0000_0200);
        wr(2'd0, 32'hFFFF_FFFF);

        // R6: mask readback and unused addresses
        wr(2'd1, 32'hA5A5_5A5A);
        rd(2'd1, v); check("R6 mask a", v, 32'hA5A5_5A5A);
        wr(2'd1, 32'h5A5A_A5A5);
        rd(2'd1, v); check("R6 mask b", v, 32'h5A5A_A5A5);
        pulse(32'h0000_0010);
        wr(2'd2, 32'hFFFF_FFFF);
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd2, v); check("R6 addr2", v, 32'h0);
        rd(2'd3, v); check("R6 addr3", v, 32'h0);
        rd(2'd1, v); check("R6 mask kept", v, 32'h5A5A_A5A5);
        rd(2'd0, v); check("R6 event kept", v, 32'h0000_0010);
        wr(2'd0, 32'hFFFF_FFFF);
        wr(2'd1, MDEF);

        // R10: held level, then dropped by clear and by mask removal
        pulse(32'h0000_2000);
        for (int i = 0; i < 5; i++) begin
            idle(1);
            check("R10 err held", {31'd0, irq_err}, 32'h1);
        end
        pulse(32'h0000_0100);
        wr(2'd0, 32'h0000_2000);
        idle(1);
        check("R10 err other source", {31'd0, irq_err}, 32'h1);
        wr(2'd1, 32'h4000_0000);
        idle(1);
        check("R10 err mask drop", {31'd0, irq_err}, 32'h0);
        pulse(32'h0000_4000);
        idle(1);
        check("R10 nrm up", {31'd0, irq_norm}, 32'h1);
        wr(2'd0, 32'h0000_4000);
        idle(1);
        check("R10 nrm drop", {31'd0, irq_norm}, 32'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog got=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule